// File: doc/BRIEF.md
# Staged-Update Clock-Enable Divider Bank

This block turns one reference tick stream into a set of slower clock-enable streams, one per downstream domain: VGA, picture, TV encoder, HDMI pixel, HDMI, interface and layer logic. Each channel has a ratio field of its own. Nothing is actually clocked differently; every consumer runs on the same clock and qualifies its work with its enable pulse.

Ratios are written into a shadow copy while a global update flag is low. Those writes leave the running dividers alone. A rising edge on the update flag commits every shadow field at once, along with a shadow choice of which tick stream feeds the bank (main or auxiliary display channel). Each divider arms the committed ratio and switches to it only when its current period ends. The old period therefore always runs to full length, and no short interval appears on any output.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset every shadow field reads 0, the main tick stream is selected (`src_active` = 0), and every channel runs at ratio 1, so each `div_ce` bit is high in the cycle after every main tick.
- R2: A committed field value v makes its channel emit exactly one enable pulse per v+1 ticks of the selected stream (ratios 1 to 8).
- R3: With `upd_flag` low, a high `wr_en[i]` loads `wr_ratio[3i+2:3i]` into shadow field i, visible on the same bits of `shadow_ratio` one cycle later; channels whose `wr_en` bit is low keep their field.
- R4: With `upd_flag` high, `wr_en` and `src_wr_en` are ignored and the shadow state does not change.
- R5: Shadow writes do not change `div_ce` or `src_active` until a commit.
- R6: A commit occurs only in the cycle where `upd_flag` goes from 0 to 1; it hands every shadow field to its channel at once, and holding the flag high does not commit again.
- R7: A channel switches to a committed ratio only at the end of its current period, so the gap between two successive pulses is always a full old or full new period.
- R8: An enable pulse appears only in the cycle after a tick of the selected stream, and with no tick the dividers hold their count.
- R9: `src_wr_val` (0 = main ticks, 1 = auxiliary ticks) is shadowed when `src_wr_en` is high and the flag is low, and it drives `src_active` and the divider input from the cycle after the commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_tick | input | 1 | Tick stream of the main display channel |
| aux_tick | input | 1 | Tick stream of the auxiliary display channel |
| upd_flag | input | 1 | Update flag; a 0 to 1 edge commits the shadow state |
| wr_en | input | 7 | Per-channel shadow write enable |
| wr_ratio | input | 21 | Packed ratio fields, 3 bits per channel, channel 0 in the low bits |
| src_wr_en | input | 1 | Shadow write enable for the source choice |
| src_wr_val | input | 1 | Source choice to shadow: 0 main, 1 auxiliary |
| div_ce | output | 7 | Clock-enable pulse per channel |
| shadow_ratio | output | 21 | Current shadow ratio fields |
| src_active | output | 1 | Tick stream currently feeding the dividers |

## Verification
A wrong count or active ratio in a channel shows up on its `div_ce` bit at the next terminal count, so at most eight selected ticks later. A pending ratio that is lost or applied early shows up as a pulse spacing that is neither the old period nor the new one, within one period after the commit. Shadow corruption is visible on `shadow_ratio` in the very next cycle, and a wrong source choice is visible on `src_active` in the cycle after the commit and on every `div_ce` bit from then on.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_AUX  = 1'b1
    } src_sel_e;

endpackage

// File: rtl/clkdiv_shadow.sv
module clkdiv_shadow #(
    parameter int NUM_DIV = 7,
    parameter int RATIO_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       upd_i,
    input  logic [NUM_DIV-1:0]         wr_en_i,
    input  logic [NUM_DIV*RATIO_W-1:0] wr_ratio_i,
    input  logic                       src_wr_en_i,
    input  logic                       src_wr_val_i,
    output logic [NUM_DIV*RATIO_W-1:0] shadow_o,
    output logic                       src_shadow_o,
    output logic                       commit_o
);
    import clkdiv_pkg::*;

    localparam int BUS_W = NUM_DIV * RATIO_W;

    typedef struct packed {
        logic [BUS_W-1:0] fields;
        src_sel_e         src;
        logic             upd_prev;
    } shd_t;

    shd_t shd_d, shd_q;

    always_comb begin
        shd_d          = shd_q;
        shd_d.upd_prev = upd_i;
        if (!upd_i) begin
            for (int i = 0; i < NUM_DIV; i++) begin
                if (wr_en_i[i]) begin
                    shd_d.fields[i*RATIO_W +: RATIO_W] = wr_ratio_i[i*RATIO_W +: RATIO_W];
                end
            end
            if (src_wr_en_i) begin
                shd_d.src = src_sel_e'(src_wr_val_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q <= '{fields: '0, src: SRC_MAIN, upd_prev: 1'b0};
        end else begin
            shd_q <= shd_d;
        end
    end

    assign commit_o     = upd_i && !shd_q.upd_prev;
    assign shadow_o     = shd_q.fields;
    assign src_shadow_o = shd_q.src;

    // R4: shadow state frozen while the flag is high
    a_r4_frozen_when_flagged: assert property (
        @(posedge clk) disable iff (!rst_n)
        upd_i |=> $stable(shd_q.fields) && $stable(shd_q.src));

    // R6: a held flag never commits twice in a row
    a_r6_single_commit: assert property (
        @(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               commit_i,
    input  logic [RATIO_W-1:0] new_ratio_i,
    output logic               ce_o
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] act;
        logic               pend_v;
        logic [RATIO_W-1:0] pend_r;
        logic               ce;
    } div_t;

    div_t div_d, div_q;
    logic at_end;

    assign at_end = (div_q.cnt == div_q.act);

    always_comb begin
        div_d    = div_q;
        div_d.ce = tick_i && at_end;
        if (tick_i) begin
            if (at_end) begin
                div_d.cnt = '0;
                if (div_q.pend_v) begin
                    div_d.act    = div_q.pend_r;
                    div_d.pend_v = 1'b0;
                end
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
        if (commit_i) begin
            div_d.pend_v = 1'b1;
            div_d.pend_r = new_ratio_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign ce_o = div_q.ce;

    // R2: the count never passes the active terminal value
    a_r2_cnt_bounded: assert property (
        @(posedge clk) disable iff (!rst_n)
        div_q.cnt <= div_q.act);

    // R7: the active ratio changes only at a terminal count
    a_r7_load_at_terminal: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(tick_i && at_end) |=> $stable(div_q.act));

    // R8: a pulse always follows a tick
    a_r8_pulse_needs_tick: assert property (
        @(posedge clk) disable iff (!rst_n)
        div_q.ce |-> $past(tick_i));

    // R6: a commit always leaves a ratio armed
    a_r6_commit_arms: assert property (
        @(posedge clk) disable iff (!rst_n)
        commit_i |=> div_q.pend_v);

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
    parameter int NUM_DIV = 7,
    parameter int RATIO_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       main_tick,
    input  logic                       aux_tick,
    input  logic                       upd_flag,
    input  logic [NUM_DIV-1:0]         wr_en,
    input  logic [NUM_DIV*RATIO_W-1:0] wr_ratio,
    input  logic                       src_wr_en,
    input  logic                       src_wr_val,
    output logic [NUM_DIV-1:0]         div_ce,
    output logic [NUM_DIV*RATIO_W-1:0] shadow_ratio,
    output logic                       src_active
);
    import clkdiv_pkg::*;

    localparam int BUS_W = NUM_DIV * RATIO_W;

    typedef struct packed {
        src_sel_e src;
    } top_t;

    top_t top_d, top_q;

    logic [BUS_W-1:0] shadow_w;
    logic             src_shadow_w;
    logic             commit_w;
    logic             tick_w;

    clkdiv_shadow #(
        .NUM_DIV (NUM_DIV),
        .RATIO_W (RATIO_W)
    ) u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .upd_i        (upd_flag),
        .wr_en_i      (wr_en),
        .wr_ratio_i   (wr_ratio),
        .src_wr_en_i  (src_wr_en),
        .src_wr_val_i (src_wr_val),
        .shadow_o     (shadow_w),
        .src_shadow_o (src_shadow_w),
        .commit_o     (commit_w)
    );

    always_comb begin
        top_d = top_q;
        if (commit_w) begin
            top_d.src = src_sel_e'(src_shadow_w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '{src: SRC_MAIN};
        end else begin
            top_q <= top_d;
        end
    end

    assign tick_w = (top_q.src == SRC_AUX) ? aux_tick : main_tick;

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_chan
        clkdiv_chan #(
            .RATIO_W (RATIO_W)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick_w),
            .commit_i    (commit_w),
            .new_ratio_i (shadow_w[g*RATIO_W +: RATIO_W]),
            .ce_o        (div_ce[g])
        );
    end

    assign shadow_ratio = shadow_w;
    assign src_active   = top_q.src;

    // R9: the active source moves only after a commit
    a_r9_src_on_commit: assert property (
        @(posedge clk) disable iff (!rst_n)
        !commit_w |=> $stable(top_q.src));

    // R5: shadow writes with the flag low leave the source alone
    a_r5_src_untouched: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!upd_flag && src_wr_en) |=> $stable(src_active));

endmodule

// File: tb/clkdiv_bank_bench.sv
module clkdiv_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 7;
    localparam int W  = 3;
    localparam int BW = N * W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          main_tick, aux_tick, upd_flag;
    logic [N-1:0]  wr_en;
    logic [BW-1:0] wr_ratio;
    logic          src_wr_en, src_wr_val;
    logic [N-1:0]  div_ce;
    logic [BW-1:0] shadow_ratio;
    logic          src_active;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_bank #(.NUM_DIV(N), .RATIO_W(W)) u_clkdiv_bank (
        .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .aux_tick(aux_tick),
        .upd_flag(upd_flag), .wr_en(wr_en), .wr_ratio(wr_ratio),
        .src_wr_en(src_wr_en), .src_wr_val(src_wr_val),
        .div_ce(div_ce), .shadow_ratio(shadow_ratio), .src_active(src_active)
    );

    int    total = 0;
    int    bad   = 0;
    string cur_req = "R1";
    logic  chk_on = 1'b0;

    // reference model state, built from the requirements
    int            m_cnt [N];
    int            m_act [N];
    int            m_pv  [N];
    int            m_pr  [N];
    logic [N-1:0]  m_ce;
    logic [BW-1:0] m_sh;
    logic          m_src_sh, m_src, m_prev;
    logic          m_tk, m_com;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_cnt[i] = 0; m_act[i] = 0; m_pv[i] = 0; m_pr[i] = 0;
            end
            m_ce = '0; m_sh = '0; m_src_sh = 1'b0; m_src = 1'b0; m_prev = 1'b0;
        end else begin
            m_tk  = m_src ? aux_tick : main_tick;
            m_com = upd_flag && !m_prev;
            for (int i = 0; i < N; i++) begin
                m_ce[i] = m_tk && (m_cnt[i] == m_act[i]);
                if (m_tk) begin
                    if (m_cnt[i] == m_act[i]) begin
                        m_cnt[i] = 0;
                        if (m_pv[i] != 0) begin
                            m_act[i] = m_pr[i];
                            m_pv[i]  = 0;
                        end
                    end else begin
                        m_cnt[i] = m_cnt[i] + 1;
                    end
                end
                if (m_com) begin
                    m_pv[i] = 1;
                    m_pr[i] = int'(m_sh[i*W +: W]);
                end
            end
            if (m_com) m_src = m_src_sh;
            if (!upd_flag) begin
                for (int i = 0; i < N; i++)
                    if (wr_en[i]) m_sh[i*W +: W] = wr_ratio[i*W +: W];
                if (src_wr_en) m_src_sh = src_wr_val;
            end
            m_prev = upd_flag;
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            chk(cur_req, "div_ce vs model", 32'(div_ce), 32'(m_ce));
            chk("R3", "shadow_ratio vs model", 32'(shadow_ratio), 32'(m_sh));
            chk("R9", "src_active vs model", 32'(src_active), 32'(m_src));
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        chk_on = 1'b0;
        summary();
    end

    initial begin
        logic [BW-1:0] pat;
        int            cnt;
        void'($urandom(32'd4242));
        rst_n = 1'b0; main_tick = 1'b0; aux_tick = 1'b0; upd_flag = 1'b0;
        wr_en = '0; wr_ratio = '0; src_wr_en = 1'b0; src_wr_val = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1", "shadow after reset", 32'(shadow_ratio), 32'd0);
        chk("R1", "source after reset", 32'(src_active), 32'd0);
        main_tick = 1'b1;
        @(negedge clk);
        chk("R1", "ratio 1 after reset", 32'(div_ce), 32'h7f);
        chk_on = 1'b1;

        // R3: shadow write, channel i gets ratio field i
        for (int i = 0; i < N; i++) pat[i*W +: W] = W'(i);
        wr_en = '1; wr_ratio = pat;
        @(negedge clk);
        wr_en = '0; wr_ratio = '0;
        chk("R3", "shadow readback", 32'(shadow_ratio), 32'(pat));
        wr_en = 7'b0000100; wr_ratio = {BW{1'b1}};
        @(negedge clk);
        wr_en = '0;
        pat[2*W +: W] = 3'd7;
        chk("R3", "single field write", 32'(shadow_ratio), 32'(pat));
        pat[2*W +: W] = 3'd2;
        wr_en = 7'b0000100; wr_ratio = pat;
        @(negedge clk);
        wr_en = '0;

        // R5: running outputs unaffected before commit
        cur_req = "R5";
        repeat (30) @(negedge clk);
        chk("R5", "still ratio 1 before commit", 32'(div_ce), 32'h7f);

        // R6: commit and hold the flag high
        cur_req = "R6";
        upd_flag = 1'b1;
        repeat (40) @(negedge clk);

        // R2: pulse counts over 840 ticks (common multiple of 1..8)
        cur_req = "R2";
        for (int i = 0; i < N; i++) begin
            cnt = 0;
            for (int c = 0; c < 840; c++) begin
                @(negedge clk);
                if (div_ce[i]) cnt++;
            end
            chk("R2", $sformatf("pulse count ch%0d", i), 32'(cnt), 32'(840 / (i + 1)));
        end

        // R4: writes ignored while flag is high
        cur_req = "R4";
        wr_en = '1; wr_ratio = BW'($urandom); src_wr_en = 1'b1; src_wr_val = 1'b1;
        @(negedge clk);
        wr_en = '0; src_wr_en = 1'b0;
        chk("R4", "shadow unchanged", 32'(shadow_ratio), 32'(pat));
        repeat (5) @(negedge clk);
        upd_flag = 1'b0;
        @(negedge clk);
        chk("R4", "source shadow not taken", 32'(src_active), 32'd0);

        // R7: change ratios mid-period, then commit
        cur_req = "R7";
        wr_en = '1; wr_ratio = {N{3'd5}};
        @(negedge clk);
        wr_en = '0;
        repeat (3) @(negedge clk);
        upd_flag = 1'b1;
        repeat (60) @(negedge clk);
        upd_flag = 1'b0;
        wr_en = '1; wr_ratio = '0;
        @(negedge clk);
        wr_en = '0;
        repeat (2) @(negedge clk);
        upd_flag = 1'b1;
        repeat (20) @(negedge clk);
        upd_flag = 1'b0;

        // R9: switch to the auxiliary stream
        cur_req = "R9";
        src_wr_en = 1'b1; src_wr_val = 1'b1;
        @(negedge clk);
        src_wr_en = 1'b0;
        chk("R9", "source unchanged before commit", 32'(src_active), 32'd0);
        upd_flag = 1'b1; aux_tick = 1'b0;
        @(negedge clk);
        chk("R9", "source after commit", 32'(src_active), 32'd1);
        repeat (10) @(negedge clk);
        chk("R8", "no pulse without aux tick", 32'(div_ce), 32'd0);

        // R8: random traffic
        cur_req = "R8";
        for (int c = 0; c < 3000; c++) begin
            main_tick = ($urandom % 4) != 0;
            aux_tick  = ($urandom % 3) != 0;
            if (($urandom % 24) == 0) upd_flag = ~upd_flag;
            wr_en     = (($urandom % 5) == 0) ? N'($urandom) : '0;
            wr_ratio  = BW'($urandom);
            src_wr_en = ($urandom % 40) == 0;
            src_wr_val = 1'($urandom);
            @(negedge clk);
        end

        chk_on = 1'b0;
        summary();
    end

endmodule